// File: doc/BRIEF.md
# Stepped Core-Supply Code Loader

This block sets the output of an external core-voltage regulator through a three-wire serial link: a data line, a shift clock and an active-high load strobe. A request carries the CPU clock frequency in kHz and a force flag. The block maps the frequency onto one of three 12-bit regulator codes and then sends serial frames until the regulator holds that code.

Without force, each frame moves the loaded code by at most a fixed increment toward the target. Large supply swings are therefore split into several small ones, so the rail never sags far enough to trip the regulator. With force, the first frame goes straight to the target. A caller uses this to pin a known state, for example at start-up when the rail already matches the running speed.

While frames are in flight, the block holds busy and ignores new requests. The code of the most recently latched frame is always visible on an output. The duration of each serial phase is a parameter in system clocks, so the roughly one-microsecond minimum per phase can be met at any system clock rate.

Top module: `vcore_step_loader`

## Requirements
- R1: The target code is 0xFFF for a frequency below 200000 kHz, 0xDE5 for a frequency from 200000 kHz up to 299999 kHz, and 0x325 for 300000 kHz and above.
- R2: Without force, each frame carries the current code plus 0x100 when the current code is below the target by more than 0x100. It carries the current code minus 0x100 when the current code is above the target by more than 0x100. Otherwise it carries the target.
- R3: With force, the first frame of a request carries the target code, and force has no effect on any later frame.
- R4: Every accepted request sends at least one frame, and frames continue until the loaded code equals the target. Busy rises on the cycle after acceptance and falls once the loaded code equals the target.
- R5: A frame shifts exactly 12 bits, most significant bit first, with one rising edge of the serial clock per bit. The data line is stable whenever the serial clock is high.
- R6: The load strobe pulses high exactly once per frame, after the twelfth clock pulse, and never while the serial clock is high. The serial clock and load are both low while idle.
- R7: Each serial-clock high pulse and each load high pulse lasts exactly PHASE_CYC system clocks. Data setup and clock-low phases are each PHASE_CYC clocks long.
- R8: After reset, the loaded code is 0xFFF, busy is low, and the serial clock, load and data lines are low.
- R9: A start request made while busy is high is ignored. The target and the frame sequence of the running request are unchanged.
- R10: The loaded-code output takes the value of a frame on the cycle its load pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| force_i | input | 1 | Send the target directly in the first frame |
| freq_khz_i | input | FREQ_W | Requested CPU frequency in kHz |
| busy_o | output | 1 | A request is being carried out |
| code_o | output | CODE_W | Code latched by the most recent frame |
| ser_data_o | output | 1 | Serial data line |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_load_o | output | 1 | Active-high load strobe |

## Verification
The assertions take for granted that start is a single-cycle strobe and that freq_khz_i and force_i are valid on the cycle start is high. The step-size property also assumes that only the first frame of a forced request may jump by more than the increment.

The bench drives each request for exactly one cycle, with the frequency and force set alongside it. It holds those inputs steady until the request ends, except for one deliberate start pulse made while busy is high, which checks that such a pulse is ignored.

// File: rtl/vcore_pkg.sv
package vcore_pkg;

    localparam int VCORE_CODE_W = 12;

    // top-level sequencing
    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_ISSUE,
        CTL_WAIT
    } ctl_state_e;

    // serial line phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW,
        PH_GAP,
        PH_LOAD
    } ser_phase_e;

    typedef struct packed {
        logic [VCORE_CODE_W-1:0] code;
        logic                    forced;
    } frame_req_t;

endpackage

// File: rtl/vcore_band_select.sv
module vcore_band_select #(
    parameter int                 FREQ_W    = 20,
    parameter int                 CODE_W    = 12,
    parameter int unsigned        LOW_KHZ   = 200000,
    parameter int unsigned        HIGH_KHZ  = 300000,
    parameter logic [CODE_W-1:0]  CODE_SLOW = 12'hFFF,
    parameter logic [CODE_W-1:0]  CODE_MID  = 12'hDE5,
    parameter logic [CODE_W-1:0]  CODE_FAST = 12'h325
) (
    input  logic [FREQ_W-1:0] freq_khz_i,
    output logic [CODE_W-1:0] code_o
);
    logic [31:0] freq_ext;

    assign freq_ext = 32'(freq_khz_i);

    always_comb begin
        if (freq_ext < LOW_KHZ)
            code_o = CODE_SLOW;
        else if (freq_ext < HIGH_KHZ)
            code_o = CODE_MID;
        else
            code_o = CODE_FAST;
    end
endmodule

// File: rtl/vcore_step_planner.sv
module vcore_step_planner #(
    parameter int                CODE_W = 12,
    parameter logic [CODE_W-1:0] STEP   = 12'h100
) (
    input  logic [CODE_W-1:0] cur_i,
    input  logic [CODE_W-1:0] tgt_i,
    input  logic              force_i,
    output logic [CODE_W-1:0] next_o
);
    localparam int EXT_W = CODE_W + 2;

    logic [EXT_W-1:0] cur_x, tgt_x, step_x;

    assign cur_x  = {2'b00, cur_i};
    assign tgt_x  = {2'b00, tgt_i};
    assign step_x = {2'b00, STEP};

    always_comb begin
        if (force_i)
            next_o = tgt_i;
        else if (cur_x + step_x < tgt_x)
            next_o = cur_i + STEP;
        else if (cur_x > tgt_x + step_x)
            next_o = cur_i - STEP;
        else
            next_o = tgt_i;
    end
endmodule

// File: rtl/vcore_frame_shifter.sv
module vcore_frame_shifter
    import vcore_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int PHASE_CYC = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] word_i,
    output logic              idle_o,
    output logic              done_o,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_load_o
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam int BIT_W = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(PHASE_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(CODE_W - 1);

    ser_phase_e        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bits_left_q;
    logic [CODE_W-1:0] shreg_q;
    logic              phase_end;

    assign phase_end = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            bits_left_q <= '0;
            shreg_q     <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (start_i) begin
                phase_q     <= PH_SETUP;
                cnt_q       <= CNT_RELOAD;
                bits_left_q <= LAST_BIT;
                shreg_q     <= word_i;
            end
        end else if (!phase_end) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            cnt_q <= CNT_RELOAD;
            unique case (phase_q)
                PH_SETUP: phase_q <= PH_HIGH;
                PH_HIGH:  phase_q <= PH_LOW;
                PH_LOW: begin
                    if (bits_left_q == '0) begin
                        phase_q <= PH_GAP;
                    end else begin
                        phase_q     <= PH_SETUP;
                        bits_left_q <= bits_left_q - 1'b1;
                        shreg_q     <= {shreg_q[CODE_W-2:0], 1'b0};
                    end
                end
                PH_GAP:  phase_q <= PH_LOAD;
                PH_LOAD: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign idle_o     = (phase_q == PH_IDLE);
    assign done_o     = (phase_q == PH_LOAD) && phase_end;
    assign ser_clk_o  = (phase_q == PH_HIGH);
    assign ser_load_o = (phase_q == PH_LOAD);
    assign ser_data_o = ((phase_q == PH_SETUP) || (phase_q == PH_HIGH) ||
                         (phase_q == PH_LOW)) ? shreg_q[CODE_W-1] : 1'b0;
endmodule

// File: rtl/vcore_step_loader.sv
module vcore_step_loader
    import vcore_pkg::*;
#(
    parameter int                       FREQ_W     = 20,
    parameter int                       PHASE_CYC  = 100,
    parameter int unsigned              LOW_KHZ    = 200000,
    parameter int unsigned              HIGH_KHZ   = 300000,
    parameter logic [VCORE_CODE_W-1:0]  CODE_SLOW  = 12'hFFF,
    parameter logic [VCORE_CODE_W-1:0]  CODE_MID   = 12'hDE5,
    parameter logic [VCORE_CODE_W-1:0]  CODE_FAST  = 12'h325,
    parameter logic [VCORE_CODE_W-1:0]  STEP       = 12'h100,
    parameter logic [VCORE_CODE_W-1:0]  RESET_CODE = 12'hFFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    force_i,
    input  logic [FREQ_W-1:0]       freq_khz_i,
    output logic                    busy_o,
    output logic [VCORE_CODE_W-1:0] code_o,
    output logic                    ser_data_o,
    output logic                    ser_clk_o,
    output logic                    ser_load_o
);
    localparam int CODE_W = VCORE_CODE_W;

    ctl_state_e        state_q;
    logic [CODE_W-1:0] cur_q;
    logic [CODE_W-1:0] target_q;
    logic              force_q;
    frame_req_t        inflight_q;
    logic [CODE_W-1:0] band_code;
    logic [CODE_W-1:0] next_code;
    logic              sh_idle, sh_done, sh_start;
    logic              accept;

    vcore_band_select #(
        .FREQ_W(FREQ_W), .CODE_W(CODE_W),
        .LOW_KHZ(LOW_KHZ), .HIGH_KHZ(HIGH_KHZ),
        .CODE_SLOW(CODE_SLOW), .CODE_MID(CODE_MID), .CODE_FAST(CODE_FAST)
    ) u_band (
        .freq_khz_i (freq_khz_i),
        .code_o     (band_code)
    );

    vcore_step_planner #(.CODE_W(CODE_W), .STEP(STEP)) u_plan (
        .cur_i   (cur_q),
        .tgt_i   (target_q),
        .force_i (force_q),
        .next_o  (next_code)
    );

    vcore_frame_shifter #(.CODE_W(CODE_W), .PHASE_CYC(PHASE_CYC)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start_i    (sh_start),
        .word_i     (next_code),
        .idle_o     (sh_idle),
        .done_o     (sh_done),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .ser_load_o (ser_load_o)
    );

    assign accept   = start_i && (state_q == CTL_IDLE);
    assign sh_start = (state_q == CTL_ISSUE) && sh_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CTL_IDLE;
            cur_q      <= RESET_CODE;
            target_q   <= RESET_CODE;
            force_q    <= 1'b0;
            inflight_q <= '0;
        end else begin
            unique case (state_q)
                CTL_IDLE: begin
                    if (accept) begin
                        target_q <= band_code;
                        force_q  <= force_i;
                        state_q  <= CTL_ISSUE;
                    end
                end
                CTL_ISSUE: begin
                    if (sh_start) begin
                        inflight_q.code   <= next_code;
                        inflight_q.forced <= force_q;
                        force_q           <= 1'b0;
                        state_q           <= CTL_WAIT;
                    end
                end
                CTL_WAIT: begin
                    if (sh_done) begin
                        cur_q   <= inflight_q.code;
                        state_q <= (inflight_q.code == target_q) ? CTL_IDLE : CTL_ISSUE;
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != CTL_IDLE);
    assign code_o = cur_q;
endmodule

// File: rtl/vcore_step_loader_chk.sv
module vcore_step_loader_chk #(
    parameter int                CODE_W    = 12,
    parameter int                PHASE_CYC = 100,
    parameter logic [CODE_W-1:0] STEP      = 12'h100
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              force_i,
    input logic              busy_o,
    input logic [CODE_W-1:0] code_o,
    input logic [CODE_W-1:0] target_q,
    input logic              ser_data_o,
    input logic              ser_clk_o,
    input logic              ser_load_o
);
    logic              forced_q;
    logic [CODE_W-1:0] code_prev_q;
    logic [CODE_W-1:0] code_dist;
    int                clk_hi_cnt, load_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            forced_q    <= 1'b0;
            code_prev_q <= '0;
            clk_hi_cnt  <= 0;
            load_hi_cnt <= 0;
        end else begin
            code_prev_q <= code_o;
            if (start_i && !busy_o)
                forced_q <= force_i;
            else if ((code_o != code_prev_q) || !busy_o)
                forced_q <= 1'b0;
            clk_hi_cnt  <= ser_clk_o  ? clk_hi_cnt + 1  : 0;
            load_hi_cnt <= ser_load_o ? load_hi_cnt + 1 : 0;
        end
    end

    assign code_dist = (code_o > code_prev_q) ? code_o - code_prev_q : code_prev_q - code_o;

    // R2: unforced frames move the loaded code by no more than the increment
    a_r2_step_cap: assert property (@(posedge clk) disable iff (rst)
        (code_o != code_prev_q) && !forced_q && $past(!rst) |-> code_dist <= STEP);

    // R4: busy only drops once the target is loaded
    a_r4_done_at_target: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> code_o == target_q);

    // R5: data never moves while the shift clock is high
    a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
        ser_clk_o |-> $stable(ser_data_o));

    // R6: clock and load quiet when idle, never high together
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ser_clk_o && !ser_load_o);
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ser_clk_o && ser_load_o));

    // R7: pulse widths
    a_r7_clk_width: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk_o) |-> clk_hi_cnt == PHASE_CYC);
    a_r7_load_width: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_load_o) |-> load_hi_cnt == PHASE_CYC);

    // R9: the target does not move during a request
    a_r9_target_held: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(target_q));
endmodule

bind vcore_step_loader vcore_step_loader_chk #(
    .CODE_W(CODE_W), .PHASE_CYC(PHASE_CYC), .STEP(STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .force_i    (force_i),
    .busy_o     (busy_o),
    .code_o     (code_o),
    .target_q   (target_q),
    .ser_data_o (ser_data_o),
    .ser_clk_o  (ser_clk_o),
    .ser_load_o (ser_load_o)
);

// File: tb/vcore_step_loader_test.sv
module vcore_step_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 3;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        force_i = 1'b0;
    logic [19:0] freq_khz_i = '0;
    logic        busy_o;
    logic [11:0] code_o;
    logic        ser_data_o, ser_clk_o, ser_load_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [11:0] exp_q[$];
    logic [11:0] model_cur = 12'hFFF;
    logic [11:0] last_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcore_step_loader #(.PHASE_CYC(PHASE)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .force_i(force_i),
        .freq_khz_i(freq_khz_i), .busy_o(busy_o), .code_o(code_o),
        .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .ser_load_o(ser_load_o)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    // R1 band table
    function automatic logic [11:0] band(input int f);
        if (f < 200000) return 12'hFFF;
        else if (f < 300000) return 12'hDE5;
        else return 12'h325;
    endfunction

    // monitor: capture bits on serial clock rise, compare at load rise (R5, R2, R3)
    logic [11:0] cap_word = '0;
    int          cap_bits = 0;
    always @(posedge ser_clk_o or posedge ser_load_o) begin
        if (ser_load_o) begin
            check(cap_bits == 12, "R5 bit count", cap_bits, 12);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected frame", int'(cap_word), 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check(cap_word == e, "R2/R3 frame word", int'(cap_word), int'(e));
            end
            last_word = cap_word;
            cap_bits  = 0;
            cap_word  = '0;
        end else begin
            cap_word = {cap_word[10:0], ser_data_o};
            cap_bits++;
        end
    end

    // pulse widths and code update timing (R6, R7, R10)
    int  hi_clk = 0, hi_load = 0;
    bit  load_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk_o) hi_clk++;
            else if (hi_clk != 0) begin
                check(hi_clk == PHASE, "R7 clock pulse width", hi_clk, PHASE);
                hi_clk = 0;
            end
            if (ser_load_o) begin
                hi_load++;
                if (ser_clk_o) check(1'b0, "R6 load with clock high", 1, 0);
            end else if (hi_load != 0) begin
                check(hi_load == PHASE, "R7 load pulse width", hi_load, PHASE);
                hi_load = 0;
            end
            if (load_prev && !ser_load_o)
                check(code_o == last_word, "R10 code after load", int'(code_o), int'(last_word));
            load_prev = ser_load_o;
        end
    end

    // driver: push the frames the requirements call for, then issue the request
    task automatic request(input int f, input bit frc, input bit intrude);
        logic [11:0] tgt, cur, nxt;
        bit          fz;
        tgt = band(f);
        cur = model_cur;
        fz  = frc;
        do begin
            if (fz) nxt = tgt;
            else if (int'(cur) + 256 < int'(tgt)) nxt = cur + 12'h100;
            else if (int'(cur) > int'(tgt) + 256) nxt = cur - 12'h100;
            else nxt = tgt;
            exp_q.push_back(nxt);
            cur = nxt;
            fz  = 1'b0;
        end while (cur != tgt);

        @(negedge clk);
        freq_khz_i = 20'(f);
        force_i    = frc;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R4 busy after start", int'(busy_o), 1);
        if (intrude) begin
            repeat (20) @(negedge clk);
            freq_khz_i = 20'd450000;
            force_i    = 1'b1;
            start_i    = 1'b1;  // R9: must be ignored
            @(negedge clk);
            start_i = 1'b0;
            force_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0, "R4 idle after request", int'(busy_o), 0);
        check(code_o == tgt, intrude ? "R9 target kept" : "R4 final code", int'(code_o), int'(tgt));
        check(exp_q.size() == 0, "R4 all frames sent", exp_q.size(), 0);
        model_cur = tgt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(code_o == 12'hFFF, "R8 reset code", int'(code_o), 12'hFFF);
        check(busy_o == 1'b0, "R8 reset busy", int'(busy_o), 0);
        check(ser_clk_o == 1'b0, "R8 reset serial clock", int'(ser_clk_o), 0);
        check(ser_load_o == 1'b0, "R8 reset load", int'(ser_load_o), 0);
        check(ser_data_o == 1'b0, "R8 reset data", int'(ser_data_o), 0);

        request(250000, 1'b0, 1'b0);  // R1 mid band, R2 downward walk
        request(400000, 1'b0, 1'b0);  // R2 long walk to fast code
        request(300000, 1'b0, 1'b0);  // R1 boundary, R4 single frame at target
        request(199999, 1'b1, 1'b0);  // R3 forced jump up
        request(200000, 1'b1, 1'b0);  // R1 lower boundary, R3 forced
        request(299999, 1'b0, 1'b0);  // R1 upper edge of mid band
        request(150000, 1'b0, 1'b1);  // R2 upward walk, R9 intrusion
        request(350000, 1'b1, 1'b0);  // R3 forced jump down
        request(100000, 1'b0, 1'b0);  // R2 long upward walk

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule